// File: doc/BRIEF.md
# Programmable Pixel-Phase Edge Generator

This block produces the fast per-pixel clocks for reading out an image sensor and for timing a correlated double sampler. Each pixel period is split into 64 phase slots. A phase counter, clocked at 64 times the pixel rate, steps through those slots. A reset-gate pulse, eight horizontal clocks, a last-stage horizontal clock and two one-slot sample strobes are each shaped from 6-bit slot positions. Optionally, the reference runs at twice that rate and the block halves it internally.

Software-style configuration enters through a narrow write port into a shadow bank. The live copy is refreshed only as the counter wraps to slot 0, so a reprogrammed edge never cuts a period short. The `slot_o` output names the phase slot that the other registered outputs currently show. A master clock output is the inverse of the reference.

Top module: `pixel_edge_gen`

## Requirements
- R1: While running, `slot_o` steps 0,1,…,63 and then back to 0. It advances once per `clk` when halving is off. Every other output shows the value computed for the slot shown on `slot_o`.
- R2: While `rst` is high, on the clock edge, `slot_o`, `rg_o`, every bit of `h_o`, `hl_o`, `shp_o` and `shd_o` are all 0. The configuration returns to its defaults: all edge positions 0, SHP position 0, SHD position 32, both polarity bits 0, fan-out mode 1 and halving off.
- R3: Let r be the RG rise position and f its fall position. The window covers slot s when r<f and r<=s<f, or when r>f and (s>=r or s<f). When r==f the window is empty. `rg_o` equals the window XOR the RG polarity bit.
- R4: `h_o[0]` (H1) follows the R3 window rule with its own rise and fall positions, XORed with its own polarity bit.
- R5: With fan-out mode 1, `h_o[2]`, `h_o[4]` and `h_o[6]` equal H1, and `h_o[1]`, `h_o[3]`, `h_o[5]` and `h_o[7]` are the inverse of H1. With mode 0, all eight bits equal H1.
- R6: `hl_o` follows the R3 window rule with its own positions and has no polarity inversion.
- R7: `shp_o` is 1 only in the slot equal to the SHP position. `shd_o` is 1 only in the slot equal to the SHD position.
- R8: With halving on, each slot value on `slot_o` lasts exactly two `clk` cycles.
- R9: A write drives `wr_en`=1 with `wr_addr` and `wr_data` for one cycle. The addresses are: 0 RG rise, 1 RG fall, 2 H1 rise, 3 H1 fall, 4 HL rise, 5 HL fall, 6 SHP position, 7 SHD position, and 8 control. The control bits are: bit0 RG polarity, bit1 H1 polarity, bit2 fan-out mode, bit3 halving. A write has no effect on the outputs before the next slot 0. It takes effect from that slot 0.
- R10: `clk_inv_o` is always the logical inverse of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 64x (or 128x when halving) the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration register address |
| wr_data | input | 6 | Configuration write data |
| slot_o | output | 6 | Phase slot the outputs currently show |
| rg_o | output | 1 | Reset-gate pulse |
| h_o | output | 8 | Horizontal clocks H1 (bit 0) to H8 (bit 7) |
| hl_o | output | 1 | Last-stage horizontal clock |
| shp_o | output | 1 | Reference-level sample strobe |
| shd_o | output | 1 | Data-level sample strobe |
| clk_inv_o | output | 1 | Inverse of the reference clock |

## Verification
The assertions assume two things: `rst` is held for at least one edge before any check matters, and writes arrive only as single-cycle strobes on the write port. They also assume the halving bit changes only through that port. Because of this, the counter's step, wrap and hold behaviour can be judged from the staged halving bit alone. The stimulus drives every write on the falling edge and holds `wr_en` high for exactly one cycle. It waits for a full period boundary before expecting new values, so each comparison concerns a single staged configuration.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int POS_W = 6;
  localparam int ADDR_W = 4;
  localparam logic [POS_W-1:0] HALF_POS = {1'b1, {(POS_W-1){1'b0}}};

  typedef enum logic [ADDR_W-1:0] {
    A_RG_RISE = 4'd0, A_RG_FALL = 4'd1, A_H1_RISE = 4'd2, A_H1_FALL = 4'd3,
    A_HL_RISE = 4'd4, A_HL_FALL = 4'd5, A_SHP_POS = 4'd6, A_SHD_POS = 4'd7,
    A_CTRL    = 4'd8
  } pe_addr_e;

  typedef struct packed {
    logic [POS_W-1:0] rg_rise;
    logic [POS_W-1:0] rg_fall;
    logic [POS_W-1:0] h1_rise;
    logic [POS_W-1:0] h1_fall;
    logic [POS_W-1:0] hl_rise;
    logic [POS_W-1:0] hl_fall;
    logic [POS_W-1:0] shp_pos;
    logic [POS_W-1:0] shd_pos;
    logic             rg_pol;
    logic             h1_pol;
    logic             hmode;
    logic             div2;
  } pe_cfg_t;

  localparam pe_cfg_t CFG_RST = '{
    rg_rise: '0, rg_fall: '0, h1_rise: '0, h1_fall: '0,
    hl_rise: '0, hl_fall: '0, shp_pos: '0, shd_pos: HALF_POS,
    rg_pol: 1'b0, h1_pol: 1'b0, hmode: 1'b1, div2: 1'b0};

  // Active window between two slot positions; equal positions give none,
  // a fall below the rise wraps across the pixel boundary.
  function automatic logic in_window(input logic [POS_W-1:0] s,
                                     input logic [POS_W-1:0] r,
                                     input logic [POS_W-1:0] f);
    if (r == f)     return 1'b0;
    else if (r < f) return (s >= r) && (s < f);
    else            return (s >= r) || (s < f);
  endfunction
endpackage

// File: rtl/pe_phase_ctr.sv
module pe_phase_ctr #(
  parameter int W = pe_pkg::POS_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         div2,
  output logic [W-1:0] ph_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] PH_MAX = {W{1'b1}};

  logic tgl_q;
  logic adv;

  assign adv    = !div2 || tgl_q;
  assign wrap_o = adv && (ph_o == PH_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_o  <= '0;
      tgl_q <= 1'b0;
    end else begin
      tgl_q <= div2 ? ~tgl_q : 1'b0;
      if (adv) ph_o <= ph_o + 1'b1;
    end
  end

  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (adv && ph_o != PH_MAX) |=> (ph_o == $past(ph_o) + 1'b1));
  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (adv && ph_o == PH_MAX) |=> (ph_o == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!adv) |=> $stable(ph_o));
endmodule

// File: rtl/pe_cfg_regs.sv
module pe_cfg_regs
  import pe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [POS_W-1:0]  wr_data,
  input  logic              load,
  output pe_cfg_t           act_o
);
  pe_cfg_t shd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q <= CFG_RST;
      act_o <= CFG_RST;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_RG_RISE: shd_q.rg_rise <= wr_data;
          A_RG_FALL: shd_q.rg_fall <= wr_data;
          A_H1_RISE: shd_q.h1_rise <= wr_data;
          A_H1_FALL: shd_q.h1_fall <= wr_data;
          A_HL_RISE: shd_q.hl_rise <= wr_data;
          A_HL_FALL: shd_q.hl_fall <= wr_data;
          A_SHP_POS: shd_q.shp_pos <= wr_data;
          A_SHD_POS: shd_q.shd_pos <= wr_data;
          A_CTRL: begin
            shd_q.rg_pol <= wr_data[0];
            shd_q.h1_pol <= wr_data[1];
            shd_q.hmode  <= wr_data[2];
            shd_q.div2   <= wr_data[3];
          end
          default: ;
        endcase
      end
      if (load) act_o <= shd_q;
    end
  end

  p_stage_r9: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> $stable(act_o));
endmodule

// File: rtl/pe_edge_gen.sv
module pe_edge_gen #(
  parameter int W = pe_pkg::POS_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] slot,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  input  logic         pol,
  output logic         q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= pol ^ pe_pkg::in_window(slot, rise, fall);
  end

  p_equal_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (rise == fall) |=> (q == $past(pol)));
endmodule

// File: rtl/pixel_edge_gen.sv
module pixel_edge_gen #(
  parameter int NH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [pe_pkg::ADDR_W-1:0] wr_addr,
  input  logic [pe_pkg::POS_W-1:0]  wr_data,
  output logic [pe_pkg::POS_W-1:0]  slot_o,
  output logic                      rg_o,
  output logic [NH-1:0]             h_o,
  output logic                      hl_o,
  output logic                      shp_o,
  output logic                      shd_o,
  output logic                      clk_inv_o
);
  import pe_pkg::*;
  localparam int NEDGE = 3;

  pe_cfg_t          act;
  logic [POS_W-1:0] ph;
  logic             wrap;
  logic             mode_q;
  logic [POS_W-1:0] rise_a [NEDGE];
  logic [POS_W-1:0] fall_a [NEDGE];
  logic             pol_a  [NEDGE];
  logic             edge_q [NEDGE];

  pe_phase_ctr #(.W(POS_W)) u_ctr (
    .clk(clk), .rst(rst), .div2(act.div2), .ph_o(ph), .wrap_o(wrap));

  pe_cfg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(wrap), .act_o(act));

  assign rise_a[0] = act.rg_rise; assign fall_a[0] = act.rg_fall; assign pol_a[0] = act.rg_pol;
  assign rise_a[1] = act.h1_rise; assign fall_a[1] = act.h1_fall; assign pol_a[1] = act.h1_pol;
  assign rise_a[2] = act.hl_rise; assign fall_a[2] = act.hl_fall; assign pol_a[2] = 1'b0;

  for (genvar g = 0; g < NEDGE; g++) begin : g_edge
    pe_edge_gen #(.W(POS_W)) u_edge (
      .clk(clk), .rst(rst), .slot(ph), .rise(rise_a[g]), .fall(fall_a[g]),
      .pol(pol_a[g]), .q(edge_q[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_o <= '0;
      shp_o  <= 1'b0;
      shd_o  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      slot_o <= ph;
      shp_o  <= (ph == act.shp_pos);
      shd_o  <= (ph == act.shd_pos);
      mode_q <= act.hmode;
    end
  end

  assign rg_o      = edge_q[0];
  assign hl_o      = edge_q[2];
  assign clk_inv_o = ~clk;

  for (genvar i = 0; i < NH; i++) begin : g_hfan
    if (i % 2 == 1) begin : g_anti
      assign h_o[i] = mode_q ? ~edge_q[1] : edge_q[1];
    end else begin : g_same
      assign h_o[i] = edge_q[1];
    end
  end

  p_shp_slot_r7: assert property (@(posedge clk) disable iff (rst)
    shp_o |-> (slot_o == $past(act.shp_pos)));
  p_shd_slot_r7: assert property (@(posedge clk) disable iff (rst)
    shd_o |-> (slot_o == $past(act.shd_pos)));
  p_fanout_r5: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> (h_o[1] == ~h_o[0] && h_o[2] == h_o[0]));
endmodule

// File: tb/tb_pixel_edge_gen.sv
module tb_pixel_edge_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [5:0] wr_data = '0;
  logic [5:0] slot_o;
  logic       rg_o, hl_o, shp_o, shd_o, clk_inv_o;
  logic [7:0] h_o;

  pixel_edge_gen dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .slot_o(slot_o), .rg_o(rg_o), .h_o(h_o), .hl_o(hl_o),
    .shp_o(shp_o), .shd_o(shd_o), .clk_inv_o(clk_inv_o));

  always #10 clk = ~clk;

  typedef struct { int slot; bit rg; bit [7:0] h; bit hl; bit shp; bit shd; } item_t;
  item_t q[$];
  int  nchk = 0, nerr = 0, last_slot = 63;
  bit  arm = 0, done = 0;

  // bench model of the configuration
  int m_rgr = 0, m_rgf = 0, m_h1r = 0, m_h1f = 0, m_hlr = 0, m_hlf = 0;
  int m_shp = 0, m_shd = 32;
  bit m_rgp = 0, m_h1p = 0, m_mode = 1, m_div = 0;

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit win(input int s, input int r, input int f);
    if (r == f) return 0;
    if (r < f)  return (s >= r && s < f);
    return (s >= r || s < f);
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 4'(a); wr_data = 6'(d);
    @(negedge clk);
    wr_en = 0;
    case (a)
      0: m_rgr = d; 1: m_rgf = d; 2: m_h1r = d; 3: m_h1f = d;
      4: m_hlr = d; 5: m_hlf = d; 6: m_shp = d; 7: m_shd = d;
      8: begin m_rgp = d[0]; m_h1p = d[1]; m_mode = d[2]; m_div = d[3]; end
      default: ;
    endcase
  endtask

  task automatic push_period();
    for (int s = 0; s < 64; s++) begin
      item_t it;
      bit h1;
      it.slot = s;
      it.rg   = win(s, m_rgr, m_rgf) ^ m_rgp;
      h1      = win(s, m_h1r, m_h1f) ^ m_h1p;
      for (int i = 0; i < 8; i++) it.h[i] = (i % 2 == 1 && m_mode) ? ~h1 : h1;
      it.hl  = win(s, m_hlr, m_hlf);
      it.shp = (s == m_shp);
      it.shd = (s == m_shd);
      q.push_back(it);
    end
  endtask

  // driver: wait for a period boundary, queue the expected period, arm monitor
  task automatic run_period(input bit mid_write);
    do @(negedge clk); while (slot_o != 6'd63);
    push_period();
    last_slot = 63;
    arm = 1;
    if (mid_write) begin
      // R9: these writes must not disturb the period already queued
      do @(negedge clk); while (slot_o != 6'd20);
      wr(0, 30); wr(1, 31); wr(6, 10); wr(8, 4'b0101);
    end
    while (q.size() != 0) @(negedge clk);
    arm = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (arm && q.size() > 0 && int'(slot_o) != last_slot) begin
      item_t it;
      it = q.pop_front();
      last_slot = int'(slot_o);
      chk("R1 slot", int'(slot_o), it.slot);
      chk("R3 rg", int'(rg_o), int'(it.rg));
      chk("R4 h1", int'(h_o[0]), int'(it.h[0]));
      chk("R5 h fanout", int'(h_o), int'(it.h));
      chk("R6 hl", int'(hl_o), int'(it.hl));
      chk("R7 shp", int'(shp_o), int'(it.shp));
      chk("R7 shd", int'(shd_o), int'(it.shd));
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 slot", int'(slot_o), 0);
    chk("R2 rg", int'(rg_o), 0);
    chk("R2 h", int'(h_o), 0);
    chk("R2 hl", int'(hl_o), 0);
    chk("R2 shp", int'(shp_o), 0);
    chk("R2 shd", int'(shd_o), 0);
    rst = 0;

    // R2 defaults in effect
    run_period(0);

    // R1: consecutive increments at full rate
    begin
      int s0;
      @(negedge clk); s0 = int'(slot_o);
      @(negedge clk); chk("R1 step", int'(slot_o), (s0 + 1) % 64);
    end

    // plain windows, fan-out mode 1
    wr(0, 2); wr(1, 10); wr(2, 0); wr(3, 32); wr(4, 40); wr(5, 48);
    wr(6, 5); wr(7, 37); wr(8, 4'b0100);
    run_period(0);

    // wrapped windows, equal rise/fall on HL, polarity, mode 0, edge strobes
    wr(0, 60); wr(1, 4); wr(2, 48); wr(3, 16); wr(4, 7); wr(5, 7);
    wr(6, 63); wr(7, 0); wr(8, 4'b0011);
    run_period(0);

    // R9: mid-period writes held off until the next slot 0
    run_period(1);
    run_period(0);

    // R8: halving on
    wr(2, 8); wr(3, 9); wr(8, 4'b1100);
    run_period(0);
    begin
      int s0;
      @(negedge clk); s0 = int'(slot_o);
      do @(negedge clk); while (int'(slot_o) == s0);
      s0 = int'(slot_o);
      @(negedge clk); chk("R8 hold", int'(slot_o), s0);
      @(negedge clk); chk("R8 next", int'(slot_o), (s0 + 1) % 64);
    end

    // R10: inverse reference output
    @(negedge clk); #1 chk("R10 low phase", int'(clk_inv_o), 1);
    @(posedge clk); #1 chk("R10 high phase", int'(clk_inv_o), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule